// File: doc/BRIEF.md
# Bayer Line Color Sequencer

This block labels every pixel of a two-by-two color-filter stream from an area sensor with its color. It also steers each pixel to one of two processing paths. One path serves green pixels. The other serves both red and blue pixels, which therefore share one set of gain and offset parameters. Lines come in two kinds. A green/red line starts with green and then alternates green and red. A blue/green line starts with blue and then alternates blue and green. The kind flips automatically at the end of every line.

A line is framed by an active-high strobe, which is sampled on each rising clock edge. While the strobe is low, the pixel position resets so that the next line begins at its first pixel, and the outputs rest at green-path defaults. Software turns the mode on and off through a small register write port. Writing 1 again to the enable bit while no line is active makes the following line a green/red line, which is how a new frame is aligned.

Writes to the other register addresses (the gain and offset registers) are never allowed to take effect in the middle of a line. A one-cycle load pulse tells the downstream parameter registers when to commit a write, and that pulse is only ever issued while the strobe is inactive.

Top module: `bayer_seq`

## Requirements
- R1: The mode enable is bit `wr_val` written to address 7 (`wr_en`=1, `wr_addr`=7). A 1 enables the mode and a 0 disables it. Writes to any other address leave the mode unchanged.
- R2: All outputs are registered and reflect the strobe sampled at the previous rising edge. After reset, `color`=01 (green), `chan_blue`=0, `pix_odd`=0, `line_type`=0 and `param_load`=0.
- R3: Color codes are 00 red, 01 green and 10 blue. On a green/red line, in-line pixel k (counted from 0) is green for even k and red for odd k.
- R4: On a blue/green line, pixel k is blue for even k and green for odd k. `line_type` is 0 for a green/red line and 1 for a blue/green line. While the mode is enabled, `line_type` toggles at the first low strobe sample after each line and stays stable during a line.
- R5: Writing 1 to the enable bit while the strobe is low sets `line_type` to 0. This holds even on the very edge where a line ends, and there the rewrite takes precedence over the toggle.
- R6: `chan_blue` is 1 for red and blue pixels and 0 for green pixels and idle cycles.
- R7: While the mode is enabled, `pix_odd` is always 0, so every pixel selects the even offset registers.
- R8: A low strobe sample resets the pixel position, so every line starts at k=0 regardless of the previous line's length. The outputs after a low sample are `color`=01 and `chan_blue`=0.
- R9: A write to any address other than 7 makes `param_load` pulse high for one cycle after the first edge that samples the strobe low. This happens at that same edge for an idle write. For a write during a line, the pulse is deferred to the edge that ends the line. `param_load` is never high after a high strobe sample.
- R10: While the mode is disabled, `color`=01, `chan_blue`=0 and `line_type` is frozen. `pix_odd` gives the plain odd/even parity of pixel k (k mod 2).
- R11: Writing 1 to the enable bit while the strobe is high does not reset `line_type`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Line strobe, high during a line |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | ADDR_W | Register write address |
| wr_val | input | 1 | Write data bit |
| color | output | 2 | Pixel color code |
| chan_blue | output | 1 | 1 selects the red/blue path, 0 the green path |
| pix_odd | output | 1 | Odd-pixel flag, selects odd offset registers |
| line_type | output | 1 | Current or next line kind, 0 green/red, 1 blue/green |
| param_load | output | 1 | Commit pulse for gain and offset writes |

## Verification
The end of a line and a rewrite of the enable bit can land on the same rising edge. The first would toggle the line kind and the second would clear it. The bench provokes this by issuing the enable write together with the first low strobe sample after a line. It then expects the next line to begin with green, which would not be the case if the toggle had won. The same edge can also carry the release of a gain write that was held back during the line, so the load pulse is judged in that cycle as well.

// File: rtl/bayer_seq.sv
module bayer_seq #(
  parameter int ADDR_W    = 3,
  parameter int MODE_ADDR = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_val,
  output logic [1:0]        color,
  output logic              chan_blue,
  output logic              pix_odd,
  output logic              line_type,
  output logic              param_load
);
  localparam logic [1:0] C_RED = 2'b00;
  localparam logic [1:0] C_GRN = 2'b01;
  localparam logic [1:0] C_BLU = 2'b10;

  logic mode_en, phase, in_line, pend;

  wire mode_wr  = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));
  wire parm_wr  = wr_en && !mode_wr;
  wire restart  = mode_wr && wr_val && !strobe;
  wire line_end = mode_en && in_line && !strobe;
  wire live     = strobe && mode_en;
  wire is_green = (phase == line_type);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_en    <= 1'b0;
      phase      <= 1'b0;
      in_line    <= 1'b0;
      pend       <= 1'b0;
      line_type  <= 1'b0;
      color      <= C_GRN;
      chan_blue  <= 1'b0;
      pix_odd    <= 1'b0;
      param_load <= 1'b0;
    end else begin
      if (mode_wr) mode_en <= wr_val;
      in_line <= strobe;
      phase   <= strobe ? ~phase : 1'b0;
      if (restart)       line_type <= 1'b0;
      else if (line_end) line_type <= ~line_type;
      color      <= (!live || is_green) ? C_GRN : (line_type ? C_BLU : C_RED);
      chan_blue  <= live && !is_green;
      pix_odd    <= strobe && !mode_en && phase;
      param_load <= (pend || parm_wr) && !strobe;
      pend       <= (pend || parm_wr) && strobe;
    end
  end
endmodule

// File: rtl/bayer_seq_chk.sv
module bayer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe,
  input logic       mode_en,
  input logic [1:0] color,
  input logic       chan_blue,
  input logic       pix_odd,
  input logic       line_type,
  input logic       param_load
);
  assert_blue_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chan_blue == (color != 2'b01));

  assert_even_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_en) |-> !pix_odd);

  assert_idle_green_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe) |-> (color == 2'b01 && !chan_blue));

  assert_load_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    param_load |-> !$past(strobe));

  assert_type_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe) |-> $stable(line_type));
endmodule

bind bayer_seq bayer_seq_chk u_chk (.*);

// File: tb/bayer_seq_tb.sv
module bayer_seq_tb;
  logic clk = 0, rst_n = 0, strobe = 0, wr_en = 0, wr_val = 0;
  logic [2:0] wr_addr = 0;
  logic [1:0] color;
  logic chan_blue, pix_odd, line_type, param_load;
  int nchk = 0, nfail = 0;
  bit men = 0, mline = 0, done = 0;

  always #2 clk = ~clk;

  bayer_seq u_dut (.clk, .rst_n, .strobe, .wr_en, .wr_addr, .wr_val,
                   .color, .chan_blue, .pix_odd, .line_type, .param_load);

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(logic s, logic we, logic [2:0] a, logic d);
    strobe = s; wr_en = we; wr_addr = a; wr_val = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic run_line(int len, bit wr_mid, bit end_restart, int pwr_k);
    for (int k = 0; k < len; k++) begin
      bit g;
      int ec;
      if (k == pwr_k) tick(1, 1, 3'd2, 0);
      else tick(1, wr_mid && k == 0, 3'd7, 1);
      g = ((k % 2) == mline);
      ec = !men ? 1 : g ? 1 : (mline ? 2 : 0);
      chk(mline ? "R4 color" : "R3 color", color, ec);
      chk("R6 chan", chan_blue, men && !g);
      chk(men ? "R7 parity" : "R10 parity", pix_odd, men ? 0 : k % 2);
      chk("R11/R4 type stable", line_type, mline);
      chk("R9 no load in line", param_load, 0);
    end
    tick(0, end_restart, 3'd7, 1);
    if (end_restart) begin mline = 0; men = 1; end
    else if (men) mline = ~mline;
    chk("R8 idle color", color, 1);
    chk("R8 idle chan", chan_blue, 0);
    chk(end_restart ? "R5 same-edge restart" : "R4 toggle", line_type, mline);
    chk("R9 deferred load", param_load, pwr_k >= 0);
    tick(0, 0, 3'd0, 0);
    chk("R9 load single", param_load, 0);
    chk("R4 idle stable", line_type, mline);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R2 reset color", color, 1);
    chk("R2 reset chan", chan_blue, 0);
    chk("R2 reset parity", pix_odd, 0);
    chk("R2 reset type", line_type, 0);
    chk("R2 reset load", param_load, 0);

    run_line(3, 0, 0, -1);
    chk("R10 disabled frozen", line_type, 0);

    tick(0, 1, 3'd7, 1); men = 1; mline = 0;
    for (int len = 1; len <= 7; len++) run_line(len, 0, 0, -1);

    run_line(4, 1, 0, -1);
    run_line(3, 0, 0, 1);

    tick(0, 1, 3'd7, 1); mline = 0;
    chk("R5 idle restart", line_type, 0);
    run_line(3, 0, 0, -1);
    run_line(5, 0, 0, -1);

    run_line(4, 0, 1, -1);
    run_line(2, 0, 0, 0);

    tick(0, 1, 3'd3, 0);
    chk("R9 idle load", param_load, 1);
    tick(0, 0, 3'd0, 0);
    chk("R9 idle load single", param_load, 0);
    run_line(3, 0, 0, -1);
    chk("R1 other addr keeps mode", line_type, mline);

    tick(0, 1, 3'd7, 0); men = 0;
    for (int len = 2; len <= 5; len++) run_line(len, 0, 0, -1);
    chk("R10 frozen type", line_type, mline);
    tick(0, 1, 3'd7, 1); men = 1; mline = 0;
    run_line(4, 0, 0, -1);
    run_line(4, 0, 0, -1);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule